// File: doc/BRIEF.md
# Soft-Edge Slow PWM Heater Driver

This block drives one heater switch with a slow pulse-width modulated signal. Each hard edge of the slow wave is replaced by a short burst of fast PWM whose duty ramps in sixteen steps. Switching a large resistive load then makes no audible click in the load or its supply.

A fast counter advances on every `tick` and wraps after 2^FAST_W counts, which is one fast period. A 7-bit heating request is doubled to an 8-bit slow duty D. The slow duty is latched only when a new slow cycle starts. The machine walks through these phases in order:

- latch
- steady off
- a one-period handover
- rise ramp
- a one-period handover
- steady on
- a one-period handover
- fall ramp
- a one-period handover

The steady phases advance once every SLOW_DIV fast periods. The ramps and the handover states advance once per fast period. A hold input freezes the steady phases at their present level for short quiet intervals.

Top module: `softedge_pwm`

## Requirements
- R1: After reset the output is low and stays low until a nonzero duty request is latched.
- R2: A request of zero latches a slow duty of zero: the output stays low for the whole slow cycle and no ramp is entered.
- R3: With P = 2^FAST_W and N = SLOW_DIV, a settled slow cycle with slow duty D (D = 2 x request, D below FULL_LIMIT) lasts (257 x N + 36) x P clock ticks. The output is high for (D x N + 18) x P of those ticks. The request is sampled only in the latch phase.
- R4: In ramp step k (k = 1..16) the compare value is k shifted left by FAST_W-4. On the rise the output is high while the fast count is below the compare value. On the fall the output is high while the count is at or above it. This gives 16 rising edges on the rise and 15 on the fall, so 31 rising edges per slow cycle.
- R5: When the doubled request is at or above FULL_LIMIT (253) at the moment the on phase would end, the fall is skipped and the output stays high.
- R6: While hold is high in the latch, steady-off or steady-on phase, the phase, the slow counter and the output level do not change.
- R7: When tick is low, the phase and the fast counter do not change, and the output settles and stays constant.
- R8: The output is registered and changes only on the cycle after a ramp phase. The steady and handover phases never produce an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Fast counter enable, one pulse per fast count |
| duty_req | input | 7 | Heating request, doubled to the 8-bit slow duty |
| hold | input | 1 | Freezes the steady phases at their current level |
| heat_out | output | 1 | Registered heater drive |

## Verification
The bench runs these duty requests in turn:

- zero, which must give a flat low output
- the smallest nonzero value, which gives the shortest on phase
- 126, the highest request that still falls
- two random requests drawn with a fixed seed
- 127, which crosses the full-on threshold

For every settled duty the bench counts the high ticks and the rising edges over exactly one slow cycle. The high count shows whether the on time follows D and the divided steady rate. The edge count tells a correct ramp from a missing, extra or glitching step. Holds taken during long high runs and long low runs, and a tick stall inside a ramp, show that the frozen output stays flat.

// File: rtl/softedge_pwm.sv
module softedge_pwm #(
  parameter int FAST_W     = 8,
  parameter int RAMP_LOG2  = 4,
  parameter int SLOW_DIV   = 8,
  parameter int FULL_LIMIT = 253
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] duty_req,
  input  logic       hold,
  output logic       heat_out
);
  localparam int STEP_SHIFT = FAST_W - RAMP_LOG2;
  localparam int DIV_W      = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0]     DIV_MAX   = DIV_W'(SLOW_DIV - 1);
  localparam logic [RAMP_LOG2-1:0] STEP_LAST = '1;
  localparam logic [8:0]           FULL_CMP  = 9'(FULL_LIMIT);

  typedef enum logic [3:0] {
    PH_LATCH, PH_OFF, PH_OFF2RISE, PH_RISE, PH_RISE2ON,
    PH_ON, PH_ON2FALL, PH_FALL, PH_FALL2OFF
  } phase_t;

  phase_t phase_q, phase_d;
  logic [FAST_W-1:0]    fcnt_q;
  logic [DIV_W-1:0]     div_q;
  logic [RAMP_LOG2-1:0] step_q;
  logic [7:0]           slow_q, duty_q;
  logic                 out_d;

  wire       period_end = tick && (fcnt_q == '1);
  wire       slow_tick  = period_end && (div_q == DIV_MAX);
  wire [7:0] req2       = {duty_req, 1'b0};
  wire [7:0] slow_inc   = slow_q + 8'd1;
  wire       steady     = (phase_q == PH_LATCH) || (phase_q == PH_OFF) || (phase_q == PH_ON);
  wire       advance    = steady ? slow_tick : period_end;
  wire       full_on    = {1'b0, req2} >= FULL_CMP;

  wire [FAST_W:0] step_num = (FAST_W + 1)'(step_q) + 1'b1;
  wire [FAST_W:0] cmp      = step_num << STEP_SHIFT;
  wire            below    = {1'b0, fcnt_q} < cmp;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LATCH:    if (!hold && req2 != 8'd0) phase_d = PH_OFF;
      PH_OFF:      if (!hold && !(slow_inc > duty_q)) phase_d = PH_OFF2RISE;
      PH_OFF2RISE: phase_d = PH_RISE;
      PH_RISE:     if (step_q == STEP_LAST) phase_d = PH_RISE2ON;
      PH_RISE2ON:  phase_d = PH_ON;
      PH_ON:       if (!hold && slow_inc >= duty_q && !full_on) phase_d = PH_ON2FALL;
      PH_ON2FALL:  phase_d = PH_FALL;
      PH_FALL:     if (step_q == STEP_LAST) phase_d = PH_FALL2OFF;
      PH_FALL2OFF: phase_d = PH_LATCH;
      default:     phase_d = PH_LATCH;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_RISE:                          out_d = below;
      PH_FALL:                          out_d = !below;
      PH_RISE2ON, PH_ON, PH_ON2FALL:    out_d = 1'b1;
      default:                          out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_LATCH;
      fcnt_q   <= '0;
      div_q    <= '0;
      step_q   <= '0;
      slow_q   <= '0;
      duty_q   <= '0;
      heat_out <= 1'b0;
    end else begin
      if (tick) fcnt_q <= fcnt_q + 1'b1;
      if (advance && phase_d != phase_q) div_q <= '0;
      else if (period_end) div_q <= (div_q == DIV_MAX) ? '0 : div_q + 1'b1;
      if (advance) begin
        phase_q <= phase_d;
        unique case (phase_q)
          PH_LATCH:               if (!hold) duty_q <= req2;
          PH_OFF, PH_ON:          if (!hold) slow_q <= slow_inc;
          PH_OFF2RISE, PH_ON2FALL: step_q <= '0;
          PH_RISE, PH_FALL:       step_q <= step_q + 1'b1;
          default:                ;
        endcase
      end
      heat_out <= out_d;
    end
  end

  AST_ZERO_STAYS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LATCH && slow_tick && !hold && duty_req == 7'd0) |=> phase_q == PH_LATCH); // R2
  AST_DUTY_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q != $past(duty_q)) |-> $past(phase_q) == PH_LATCH); // R3
  AST_RAMP_STARTS_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_OFF2RISE && phase_q == PH_RISE) |-> step_q == '0); // R4
  AST_FULL_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && slow_tick && !hold && full_on) |=> phase_q == PH_ON); // R5
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && steady && slow_tick) |=> (phase_q == $past(phase_q)) && $stable(slow_q) && $stable(duty_q)); // R6
  AST_IDLE_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (phase_q == $past(phase_q)) && $stable(fcnt_q)); // R7
  AST_EDGE_ONLY_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (heat_out != $past(heat_out)) |-> ($past(phase_q) == PH_RISE || $past(phase_q) == PH_FALL)); // R8
endmodule

// File: tb/softedge_pwm_tb.sv
`timescale 1ns/1ps
module softedge_pwm_tb_top;
  localparam int FW = 4;
  localparam int ND = 2;
  localparam int P  = 1 << FW;
  localparam int CYC = (257 * ND + 36) * P;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, hold = 1'b0;
  logic [6:0] duty_req = 7'd0;
  logic heat_out;
  int nchecks = 0, nerrs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  softedge_pwm #(.FAST_W(FW), .RAMP_LOG2(4), .SLOW_DIV(ND), .FULL_LIMIT(253)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty_req(duty_req), .hold(hold), .heat_out(heat_out));

  function automatic int exp_high(int d);
    return (d * ND + 18) * P;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0; prev = heat_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (heat_out) hi++;
      if (heat_out && !prev) rises++;
      prev = heat_out;
    end
  endtask

  task automatic wait_streak(input logic lvl, input int len);
    int c = 0;
    while (c < len) begin
      @(negedge clk);
      c = (heat_out == lvl) ? c + 1 : 0;
    end
  endtask

  initial begin
    int hi, ri, flips;
    int reqs[4];
    logic v;
    void'($urandom(32'h5eed_0017));
    reqs[0] = 1;
    reqs[1] = 126;
    reqs[2] = 2 + int'($urandom % 120);
    reqs[3] = 2 + int'($urandom % 120);

    run_cycles(5);
    rst_n = 1'b1;
    measure(20, hi, ri);
    check(hi == 0, "R1 reset output low", hi, 0);

    measure(6000, hi, ri);
    check(hi == 0 && ri == 0, "R2 zero duty stays low", hi + ri, 0);

    for (int i = 0; i < 4; i++) begin
      duty_req = 7'(reqs[i]);
      run_cycles(2 * CYC);
      measure(CYC, hi, ri);
      check(hi == exp_high(2 * reqs[i]), "R3 high ticks per slow cycle", hi, exp_high(2 * reqs[i]));
      check(ri == 31, "R4 R8 rising edges per slow cycle", ri, 31);
    end

    @(posedge heat_out);
    @(negedge clk);
    tick = 1'b0;
    run_cycles(2);
    v = heat_out; flips = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (heat_out != v) flips++;
    end
    check(flips == 0, "R7 no tick keeps output", flips, 0);
    tick = 1'b1;

    duty_req = 7'd127;
    run_cycles(2 * CYC);
    measure(CYC, hi, ri);
    check(hi == CYC && ri == 0, "R5 full request stays on", hi, CYC);

    wait_streak(1'b1, 100);
    hold = 1'b1;
    measure(4000, hi, ri);
    check(hi == 4000, "R6 hold keeps high level", hi, 4000);
    hold = 1'b0;
    duty_req = 7'd64;
    wait_streak(1'b0, 100);
    hold = 1'b1;
    measure(4000, hi, ri);
    check(hi == 0 && ri == 0, "R6 hold keeps low level", hi + ri, 0);
    hold = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerrs++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end
endmodule